// File: doc/BRIEF.md
# Oscillator Power Control Arbiter

This block decides on every clock cycle whether an oscillator macrocell should be powered. The analog oscillator is represented only by the enable output, `osc_en`. The decision combines four inputs. The first is a configured power mode: auto, or always on. The second is a shared control pin, which acts either as a kill or as a force depending on a configured pin mode. The third is a clock-source select, because an external clock input makes the kill have no effect. The fourth is demand from a set of delay-timer clients.

In auto mode, a rising edge on any delay-timer start line wakes the oscillator. The block keeps a count of pending delays. The oscillator stays on until done pulses have brought that count back to zero. Counter clients are also connected, but they can never wake the oscillator.

A second output, `clk_valid`, reports when the clock is usable. It rises a programmable number of warm-up cycles after the enable rises, and auto mode adds a fixed number of further cycles to that warm-up. It drops in the same cycle as the enable. The control pin is asynchronous and is passed through a synchronizer before use. All configuration inputs are sampled on the clock.

Top module: `osc_pwr_arbiter`

## Requirements
- R1: While reset is held, and after its release in auto mode with no demand, `osc_en` and `clk_valid` are 0.
- R2: In auto mode (`cfg_pwr_mode`=0), a 0-to-1 transition on any bit of `dly_start` sets `osc_en` on the next cycle. A start line held high counts as a single start. `osc_en` stays 1 while the pending-delay count is nonzero, and it is 0 on the cycle after the `dly_done` pulse that brings the count to zero.
- R3: A start edge and a done pulse in the same cycle leave the pending count unchanged. A done pulse arriving while the count is zero is ignored. The count saturates at 2^CNT_W-1.
- R4: Activity on `cnt_req` never sets `osc_en`.
- R5: With `cfg_pwr_mode`=1 (forced), `osc_en` is 1 from the cycle after the mode is selected, unless a kill applies. Returning to auto with no demand clears `osc_en` on the next cycle.
- R6: With `cfg_pin_mode`=0 (power-down) and `cfg_src_ext`=0 (internal), a high `ctl_pin` clears `osc_en` on the third cycle after the pin changes. This overrides both forced mode and delay demand. The pending count is kept, so releasing the pin restores the enable.
- R7: With `cfg_src_ext`=1 (external), a high `ctl_pin` in power-down pin mode has no effect on `osc_en`.
- R8: With `cfg_pin_mode`=1 (force-on), a high `ctl_pin` sets `osc_en` on the third cycle after the pin change. A low pin leaves `osc_en` to the power mode.
- R9: `clk_valid` rises `cfg_warmup` cycles after `osc_en` rises in forced mode, and `cfg_warmup`+AUTO_EXTRA cycles after it in auto mode. A `cfg_warmup` of 0 in forced mode raises both outputs in the same cycle.
- R10: `clk_valid` is never 1 while `osc_en` is 0, and it falls in the same cycle as `osc_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pin_mode | input | 1 | 0 = pin kills, 1 = pin forces on |
| ctl_pin | input | 1 | Asynchronous control pin |
| cfg_pwr_mode | input | 1 | 0 = auto, 1 = always on |
| cfg_src_ext | input | 1 | 0 = internal oscillator, 1 = external clock |
| cfg_warmup | input | WARM_W | Warm-up cycles before the clock is reported valid |
| dly_start | input | N_DLY | Delay-timer start lines, one per client (rising edge counts) |
| dly_done | input | N_DLY | Delay-timer done pulses, one per client |
| cnt_req | input | N_CNT | Counter-client activity (cannot wake the oscillator) |
| osc_en | output | 1 | Oscillator enable |
| clk_valid | output | 1 | Clock usable after warm-up |

## Verification
On every cycle, the assertions check the following against the synchronized pin and the configuration sampled at the same edge:
- the kill and force overrides;
- forced mode holding the enable on;
- counter-only activity leaving an idle oscillator off;
- clamping of the pending count at zero and at its maximum;
- the unchanged count when starts and dones balance;
- `clk_valid` never running ahead of the enable.

Only the bench scenarios can show the following:
- the exact three-cycle latency through the pin synchronizer;
- the warm-up lengths that differ between auto and forced mode;
- a held start line counting once;
- a kill releasing back to a retained delay demand.

// File: rtl/osc_pwr_pkg.sv
package osc_pwr_pkg;

   typedef enum logic {
      PIN_KILL  = 1'b0,
      PIN_FORCE = 1'b1
   } pin_mode_e;

   typedef enum logic {
      PWR_AUTO   = 1'b0,
      PWR_FORCED = 1'b1
   } pwr_mode_e;

   localparam int unsigned MAX_CLIENTS = 32;

   // number of set bits in a client vector (up to MAX_CLIENTS wide)
   function automatic logic [5:0] ones32(input logic [31:0] v);
      logic [5:0] acc;
      acc = '0;
      for (int i = 0; i < 32; i++) begin
         acc = acc + {5'd0, v[i]};
      end
      return acc;
   endfunction

endpackage

// File: rtl/osc_pin_sync.sv
module osc_pin_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic pin_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("osc_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_async};
      end
   end

   assign pin_sync = chain_q[STAGES-1];

endmodule

// File: rtl/osc_demand_track.sv
module osc_demand_track
   import osc_pwr_pkg::*;
#(
   parameter int unsigned N_DLY = 4,
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_DLY-1:0] dly_start,
   input  logic [N_DLY-1:0] dly_done,
   output logic [N_DLY-1:0] start_edge,
   output logic [CNT_W-1:0] dem_cnt,
   output logic             dem_next_nz
);

   localparam int CNT_MAX = (1 << CNT_W) - 1;

   if (N_DLY < 1 || N_DLY > MAX_CLIENTS) begin : g_bad_clients
      $error("osc_demand_track: N_DLY out of range");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("osc_demand_track: CNT_W out of range");
   end

   logic [N_DLY-1:0] start_prev_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic [5:0]       n_up;
   logic [5:0]       n_dn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_prev_q <= '0;
      end else begin
         start_prev_q <= dly_start;
      end
   end

   assign start_edge = dly_start & ~start_prev_q;
   assign n_up       = ones32(32'(start_edge));
   assign n_dn       = ones32(32'(dly_done));

   always_comb begin
      int sum;
      sum = int'(cnt_q) + int'(n_up) - int'(n_dn);
      if (sum < 0) begin
         sum = 0;
      end else if (sum > CNT_MAX) begin
         sum = CNT_MAX;
      end
      cnt_d = CNT_W'(sum);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_d;
      end
   end

   assign dem_cnt     = cnt_q;
   assign dem_next_nz = (cnt_d != '0);

endmodule

// File: rtl/osc_warmup.sv
module osc_warmup #(
   parameter int unsigned WARM_W     = 8,
   parameter int unsigned AUTO_EXTRA = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_q,
   input  logic              auto_mode,
   input  logic [WARM_W-1:0] cfg_warmup,
   output logic              clk_valid
);

   localparam int unsigned TGT_W = WARM_W + 1 + $clog2(AUTO_EXTRA + 1);

   if (WARM_W < 1 || WARM_W > 24) begin : g_bad_warm
      $error("osc_warmup: WARM_W out of range");
   end

   logic [TGT_W-1:0] target;
   logic [TGT_W-1:0] wcnt_q;

   always_comb begin
      target = TGT_W'(cfg_warmup);
      if (auto_mode) begin
         target = target + TGT_W'(AUTO_EXTRA);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt_q <= '0;
      end else if (!en_q) begin
         wcnt_q <= '0;
      end else if (wcnt_q < target) begin
         wcnt_q <= wcnt_q + 1'b1;
      end
   end

   assign clk_valid = en_q & (wcnt_q >= target);

endmodule

// File: rtl/osc_pwr_arbiter.sv
module osc_pwr_arbiter
   import osc_pwr_pkg::*;
#(
   parameter int unsigned N_DLY       = 4,
   parameter int unsigned N_CNT       = 2,
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned WARM_W      = 8,
   parameter int unsigned AUTO_EXTRA  = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_pin_mode,
   input  logic              ctl_pin,
   input  logic              cfg_pwr_mode,
   input  logic              cfg_src_ext,
   input  logic [WARM_W-1:0] cfg_warmup,
   input  logic [N_DLY-1:0]  dly_start,
   input  logic [N_DLY-1:0]  dly_done,
   input  logic [N_CNT-1:0]  cnt_req,
   output logic              osc_en,
   output logic              clk_valid
);

   if (N_CNT < 1) begin : g_bad_cnt_clients
      $error("osc_pwr_arbiter: N_CNT must be at least 1");
   end

   pin_mode_e        pin_mode;
   pwr_mode_e        pwr_mode;
   logic             pin_sync;
   logic [N_DLY-1:0] start_edge;
   logic [CNT_W-1:0] dem_cnt;
   logic             dem_next_nz;
   logic             kill;
   logic             force_on;
   logic             want;
   logic             osc_en_q;
   logic             unused_cnt_req;

   assign pin_mode = pin_mode_e'(cfg_pin_mode);
   assign pwr_mode = pwr_mode_e'(cfg_pwr_mode);

   // counter clients are observed but are not a wake source
   assign unused_cnt_req = ^cnt_req;

   osc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_async (ctl_pin),
      .pin_sync  (pin_sync)
   );

   osc_demand_track #(.N_DLY(N_DLY), .CNT_W(CNT_W)) u_demand (
      .clk         (clk),
      .rst_n       (rst_n),
      .dly_start   (dly_start),
      .dly_done    (dly_done),
      .start_edge  (start_edge),
      .dem_cnt     (dem_cnt),
      .dem_next_nz (dem_next_nz)
   );

   assign kill     = (pin_mode == PIN_KILL) & pin_sync & ~cfg_src_ext;
   assign force_on = (pin_mode == PIN_FORCE) & pin_sync;
   assign want     = (pwr_mode == PWR_FORCED) | dem_next_nz;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         osc_en_q <= 1'b0;
      end else begin
         osc_en_q <= ~kill & (force_on | want);
      end
   end

   osc_warmup #(.WARM_W(WARM_W), .AUTO_EXTRA(AUTO_EXTRA)) u_warm (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_q       (osc_en_q),
      .auto_mode  (pwr_mode == PWR_AUTO),
      .cfg_warmup (cfg_warmup),
      .clk_valid  (clk_valid)
   );

   assign osc_en = osc_en_q;

endmodule

// File: rtl/osc_pwr_arbiter_chk.sv
module osc_pwr_arbiter_chk #(
   parameter int unsigned N_DLY  = 4,
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned WARM_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_pin_mode,
   input logic              cfg_pwr_mode,
   input logic              cfg_src_ext,
   input logic [WARM_W-1:0] cfg_warmup,
   input logic              pin_sync,
   input logic [N_DLY-1:0]  start_edge,
   input logic [N_DLY-1:0]  dly_done,
   input logic [CNT_W-1:0]  dem_cnt,
   input logic              osc_en,
   input logic              clk_valid
);

   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   // R6: kill through the synchronized pin turns the enable off
   assert_kill_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_pin_mode && pin_sync && !cfg_src_ext) |=> !osc_en);

   // R8: force through the synchronized pin turns the enable on
   assert_force_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pin_mode && pin_sync) |=> osc_en);

   // R5: forced mode keeps the oscillator running without a kill
   assert_forced_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pwr_mode && !(!cfg_pin_mode && pin_sync && !cfg_src_ext)) |=> osc_en);

   // R4: counters alone cannot wake an idle auto oscillator
   assert_no_cnt_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_pwr_mode && !(cfg_pin_mode && pin_sync) && dem_cnt == '0 && start_edge == '0)
      |=> !osc_en);

   // R3: no underflow on a done with nothing pending
   assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dem_cnt == '0 && start_edge == '0) |=> dem_cnt == '0);

   // R3: saturation at the top of the count
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dem_cnt == CMAX && $countones(start_edge) >= $countones(dly_done)) |=> dem_cnt == CMAX);

   // R3: balanced start and done leave the count alone
   assert_balanced_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(start_edge) == $countones(dly_done)) |=> $stable(dem_cnt));

   // R10: valid never without enable
   assert_valid_needs_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clk_valid |-> osc_en);

   // R9: nonzero warm-up means valid lags the enable
   assert_valid_lags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(clk_valid) && cfg_warmup != '0) |-> $past(osc_en));

endmodule

bind osc_pwr_arbiter osc_pwr_arbiter_chk #(
   .N_DLY  (N_DLY),
   .CNT_W  (CNT_W),
   .WARM_W (WARM_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_pin_mode (cfg_pin_mode),
   .cfg_pwr_mode (cfg_pwr_mode),
   .cfg_src_ext  (cfg_src_ext),
   .cfg_warmup   (cfg_warmup),
   .pin_sync     (pin_sync),
   .start_edge   (start_edge),
   .dly_done     (dly_done),
   .dem_cnt      (dem_cnt),
   .osc_en       (osc_en),
   .clk_valid    (clk_valid)
);

// File: tb/osc_pwr_arbiter_bench.sv
`timescale 1ns/1ps
module osc_pwr_arbiter_bench;

   localparam int N_DLY = 3;
   localparam int N_CNT = 2;
   localparam int WARM_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_pin_mode = 1'b0;
   logic ctl_pin = 1'b0;
   logic cfg_pwr_mode = 1'b0;
   logic cfg_src_ext = 1'b0;
   logic [WARM_W-1:0] cfg_warmup = 8'd3;
   logic [N_DLY-1:0] dly_start = '0;
   logic [N_DLY-1:0] dly_done = '0;
   logic [N_CNT-1:0] cnt_req = '0;
   logic osc_en;
   logic clk_valid;

   int cyc = 0;
   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   typedef struct {
      int    at;
      bit    en;
      bit    val;
      bit    use_val;
      string tag;
   } exp_t;
   exp_t sb[$];

   osc_pwr_arbiter #(
      .N_DLY(N_DLY), .N_CNT(N_CNT), .CNT_W(4),
      .WARM_W(WARM_W), .AUTO_EXTRA(2), .SYNC_STAGES(2)
   ) u_osc_pwr_arbiter (
      .clk(clk), .rst_n(rst_n), .cfg_pin_mode(cfg_pin_mode), .ctl_pin(ctl_pin),
      .cfg_pwr_mode(cfg_pwr_mode), .cfg_src_ext(cfg_src_ext), .cfg_warmup(cfg_warmup),
      .dly_start(dly_start), .dly_done(dly_done), .cnt_req(cnt_req),
      .osc_en(osc_en), .clk_valid(clk_valid)
   );

   initial forever #2 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   // driver side: queue an expectation d cycles ahead
   task automatic exp_at(input int d, input bit en, input bit val, input bit use_val,
                         input string tag);
      exp_t it;
      int   i;
      it.at = cyc + d; it.en = en; it.val = val; it.use_val = use_val; it.tag = tag;
      i = 0;
      while (i < sb.size() && sb[i].at <= it.at) i++;
      sb.insert(i, it);
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_start(input int i);
      dly_start[i] = 1'b1;
      @(negedge clk);
      dly_start[i] = 1'b0;
   endtask

   task automatic pulse_done(input int i);
      dly_done[i] = 1'b1;
      @(negedge clk);
      dly_done[i] = 1'b0;
   endtask

   // monitor: compare outputs shortly after each rising edge
   initial forever begin
      @(posedge clk);
      #1;
      while (sb.size() > 0 && sb[0].at <= cyc) begin
         exp_t it;
         it = sb.pop_front();
         n_chk++;
         if (it.at != cyc) begin
            n_err++;
            $display("FAIL %s: check for cycle %0d missed (now %0d), expected osc_en=%0b",
                     it.tag, it.at, cyc, it.en);
         end else if (osc_en !== it.en || (it.use_val && clk_valid !== it.val)) begin
            n_err++;
            $display("FAIL %s: cycle %0d osc_en=%0b clk_valid=%0b expected osc_en=%0b clk_valid=%0b%s",
                     it.tag, cyc, osc_en, clk_valid, it.en, it.val,
                     it.use_val ? "" : " (valid not checked)");
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      wait_cyc(2);
      exp_at(1, 0, 0, 1, "R1 in reset");
      wait_cyc(2);
      rst_n = 1'b1;
      exp_at(2, 0, 0, 1, "R1 after reset");
      wait_cyc(4);

      // R4: counter activity does not wake
      cnt_req = 2'b11;
      exp_at(1, 0, 0, 1, "R4");
      exp_at(4, 0, 0, 1, "R4");
      wait_cyc(5);
      cnt_req = 2'b00;
      wait_cyc(2);

      // R2 / R9: auto wake and auto warm-up (3 + 2)
      exp_at(1, 1, 0, 1, "R2 wake");
      exp_at(5, 1, 0, 1, "R9 auto early");
      exp_at(6, 1, 1, 1, "R9 auto valid");
      pulse_start(0);
      wait_cyc(7);
      pulse_start(1);
      wait_cyc(2);
      exp_at(1, 1, 1, 1, "R2 still pending");
      pulse_done(0);
      wait_cyc(3);
      exp_at(1, 0, 0, 1, "R2 last done");
      exp_at(1, 0, 0, 1, "R10 falls together");
      pulse_done(1);
      wait_cyc(3);

      // R3: same-cycle start and done
      pulse_start(0);
      wait_cyc(2);
      dly_start[1] = 1'b1;
      dly_done[0] = 1'b1;
      exp_at(1, 1, 0, 0, "R3 balanced");
      exp_at(3, 1, 0, 0, "R3 balanced");
      @(negedge clk);
      dly_start[1] = 1'b0;
      dly_done[0] = 1'b0;
      wait_cyc(3);
      exp_at(1, 0, 0, 1, "R3 count was one");
      pulse_done(1);
      wait_cyc(2);

      // R3 underflow, R2 held start counts once
      exp_at(1, 0, 0, 1, "R3 done at zero");
      pulse_done(2);
      wait_cyc(2);
      exp_at(1, 1, 0, 0, "R2 held start");
      dly_start[0] = 1'b1;
      wait_cyc(4);
      dly_start[0] = 1'b0;
      wait_cyc(2);
      exp_at(1, 0, 0, 1, "R2 held start counted once");
      pulse_done(0);
      wait_cyc(2);

      // R6: kill overrides delay demand, count retained
      pulse_start(0);
      wait_cyc(2);
      ctl_pin = 1'b1;
      exp_at(2, 1, 0, 0, "R6 before sync");
      exp_at(3, 0, 0, 1, "R6 kill demand");
      wait_cyc(6);
      ctl_pin = 1'b0;
      exp_at(3, 1, 0, 1, "R6 demand retained");
      exp_at(7, 1, 0, 1, "R9 auto early");
      exp_at(8, 1, 1, 1, "R9 auto valid");
      wait_cyc(10);
      exp_at(1, 0, 0, 1, "R2 done after kill");
      pulse_done(0);
      wait_cyc(3);

      // R5 / R9: forced mode and its shorter warm-up
      cfg_pwr_mode = 1'b1;
      exp_at(1, 1, 0, 1, "R5 forced on");
      exp_at(3, 1, 0, 1, "R9 forced early");
      exp_at(4, 1, 1, 1, "R9 forced valid");
      wait_cyc(6);

      // R6 kill in forced mode
      ctl_pin = 1'b1;
      exp_at(2, 1, 1, 1, "R6 before sync");
      exp_at(3, 0, 0, 1, "R6 kill forced");
      wait_cyc(5);

      // R7: external source ignores the kill
      cfg_src_ext = 1'b1;
      exp_at(1, 1, 0, 1, "R7 ext ignores kill");
      exp_at(4, 1, 1, 1, "R7 ext valid");
      wait_cyc(6);
      cfg_src_ext = 1'b0;
      exp_at(1, 0, 0, 1, "R6 internal again");
      wait_cyc(2);
      ctl_pin = 1'b0;
      wait_cyc(5);
      ctl_pin = 1'b1;
      wait_cyc(5);

      // R9: zero warm-up in forced mode
      cfg_warmup = 8'd0;
      ctl_pin = 1'b0;
      exp_at(2, 0, 0, 1, "R9 zero warm before");
      exp_at(3, 1, 1, 1, "R9 zero warm");
      wait_cyc(5);

      // R5: back to auto with no demand
      cfg_pwr_mode = 1'b0;
      cfg_warmup = 8'd3;
      exp_at(1, 0, 0, 1, "R5 auto idle");
      wait_cyc(3);

      // R8: force-on pin mode
      cfg_pin_mode = 1'b1;
      exp_at(2, 0, 0, 1, "R8 low pin");
      wait_cyc(3);
      ctl_pin = 1'b1;
      exp_at(2, 0, 0, 1, "R8 before sync");
      exp_at(3, 1, 0, 1, "R8 forced by pin");
      exp_at(7, 1, 0, 1, "R9 auto early");
      exp_at(8, 1, 1, 1, "R9 auto valid");
      wait_cyc(10);
      ctl_pin = 1'b0;
      exp_at(2, 1, 1, 1, "R8 before release");
      exp_at(3, 0, 0, 1, "R8 release");
      wait_cyc(5);
      cfg_pwr_mode = 1'b1;
      exp_at(1, 1, 0, 1, "R8 low pin leaves power mode");
      wait_cyc(12);

      while (sb.size() > 0) begin
         exp_t it;
         it = sb.pop_front();
         n_chk++;
         n_err++;
         $display("FAIL %s: never checked, expected osc_en=%0b at cycle %0d actual=none",
                  it.tag, it.en, it.at);
      end
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule